// File: doc/BRIEF.md
# Maintenance Wraparound Control Register

This block is the maintenance control and status word of a tape data formatter. Software uses it to put the formatter into a test mode, to choose one test function through a 4-bit code, and to step the data path by hand. When maintenance mode is on, the selected code turns into one of several fault-injection controls for the neighbouring formatter logic. These controls can corrupt parity, block the write clock, break transfers, skip CRC initialisation, hold a data bit high or spoil the preamble. One code asks for the running operation to end by dropping GO.

The register also holds a 9-bit character field. This field is loaded from the bus or by a capture strobe on the wraparound path. A read-only bit shows the character-rate clock, sampled once per cycle. The step bit toggles on bus writes for some codes and on formatter read strobes for one other code. This lets a program move one character at a time through the loop and look at the result. Setting the mode bit does nothing by itself. It only changes how later commands run.

Top module: `maint_wrap_reg`

## Requirements
- R1: After reset every bit of `rdata` is 0 and every control output is 0. Bit 6 then follows `char_clk` with one register delay.
- R2: A bus write loads bits 15..7 (data field), bits 4..1 (code) and bit 0 (mode enable) from `bus_wdata`. When no step applies, it also loads bit 5 (step bit). `rdata` shows the stored word in the same layout.
- R3: Bit 6 of `rdata` equals `char_clk` as sampled at the previous clock edge. Bus writes to bit 6 have no effect.
- R4: When `cap_valid` is high, the data field loads `cap_data` (data bit 0 = parity, bit 1 = character LSB, upward in order). A bus write in the same cycle wins.
- R5: When `go` and the mode bit are 1 and the stored code is 0100, 0101 or 0110, a bus write toggles bit 5 instead of loading it.
- R6: When `go` and the mode bit are 1 and the stored code is 0011, each cycle with `rd_strobe` high toggles bit 5 at the next edge. Without `go`, or with another code, the strobe has no effect.
- R7: With the mode bit set, the stored code drives one output: 0010 drives `even_par`, 0110 drives `no_wclk`, 0111 drives `cripple`, 1000 drives `no_crc_init`, 1001 drives `stick_bit5`, and 1011 drives `bad_preamble`.
- R8: `eor_clr_go` is high exactly when the mode bit is 1, the code is 1010 and `go` is 1.
- R9: With the mode bit at 0, all control outputs are 0. Codes 0000, 0001, 0011, 0100, 0101 and 1100 to 1111 drive no output.
- R10: `drv_clear` clears bits 15..7 and 5..0 at the next edge. It takes priority over a bus write, a capture and a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system init |
| drv_clear | input | 1 | Synchronous drive clear |
| bus_wr | input | 1 | Bus write strobe for this register |
| bus_wdata | input | 16 | Bus write data |
| go | input | 1 | Command in progress |
| rd_strobe | input | 1 | Formatter read strobe |
| char_clk | input | 1 | Character-rate clock to display |
| cap_valid | input | 1 | Wraparound capture strobe |
| cap_data | input | 9 | Wraparound character with parity |
| rdata | output | 16 | Register contents |
| even_par | output | 1 | Force even parity toward controller |
| no_wclk | output | 1 | Suppress write clock reception |
| cripple | output | 1 | Make data transfers fail on timing |
| no_crc_init | output | 1 | Suppress CRC checker initialisation |
| stick_bit5 | output | 1 | Hold data bit 5 asserted |
| bad_preamble | output | 1 | Invert preamble/postamble bit 1 |
| eor_clr_go | output | 1 | Maintenance end of record, clear GO |

## Verification
The hardest case to reach is a step event that lands together with other updates to the register. Examples are a read strobe in the same cycle as a bus write, or a write-step while a capture is pending. In these cases the step bit must toggle while the other fields still load. These cases only occur once a write has already stored the matching code and mode with `go` held high. The random phase therefore draws codes from a narrow set around the stepping codes and keeps `go` and the mode bit high most of the time. Directed cases also stack a drive clear on top of a write and a capture.

// File: rtl/maint_wrap_pkg.sv
package maint_wrap_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NULL      = 4'd0,
    OP_INTCHG    = 4'd1,
    OP_EVEN_PAR  = 4'd2,
    OP_WRAP_FULL = 4'd3,
    OP_WRAP_PART = 4'd4,
    OP_WRAP_FWR  = 4'd5,
    OP_WRAP_FRD  = 4'd6,
    OP_CRIPPLE   = 4'd7,
    OP_NO_CRC    = 4'd8,
    OP_STICK5    = 4'd9,
    OP_EOR       = 4'd10,
    OP_BAD_PRE   = 4'd11
  } mop_e;

  localparam int NCTL = 7;

  typedef struct packed {
    logic eor_clr_go;
    logic bad_preamble;
    logic stick_bit5;
    logic no_crc_init;
    logic cripple;
    logic no_wclk;
    logic even_par;
  } fault_ctl_t;
endpackage

// File: rtl/mwr_rst_sync.sv
module mwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/mwr_op_decode.sv
module mwr_op_decode
  import maint_wrap_pkg::*;
(
  input  logic            mm_en,
  input  logic [OP_W-1:0] op,
  input  logic            go,
  output fault_ctl_t      ctl
);
  // code for each control, index order matches fault_ctl_t LSB first
  localparam logic [OP_W-1:0] CODE_OF [NCTL] = '{
    OP_EVEN_PAR, OP_WRAP_FRD, OP_CRIPPLE, OP_NO_CRC,
    OP_STICK5, OP_BAD_PRE, OP_EOR
  };
  localparam int EOR_IDX = NCTL - 1;

  logic [NCTL-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < NCTL; i++) begin : g_dec
      if (i == EOR_IDX) begin : g_eor
        assign hit[i] = mm_en && go && (op == CODE_OF[i]);
      end else begin : g_plain
        assign hit[i] = mm_en && (op == CODE_OF[i]);
      end
    end
  endgenerate

  assign ctl = fault_ctl_t'(hit);
endmodule

// File: rtl/mwr_clk_step.sv
module mwr_clk_step
  import maint_wrap_pkg::*;
(
  input  logic            mm_en,
  input  logic            go,
  input  logic [OP_W-1:0] op,
  input  logic            bus_wr,
  input  logic            rd_strobe,
  input  logic            mc_q,
  input  logic            wr_mc,
  output logic            mc_d,
  output logic            step
);
  logic wr_code, strobe_code;

  always_comb begin
    wr_code     = (op == OP_WRAP_PART) || (op == OP_WRAP_FWR) ||
                  (op == OP_WRAP_FRD);
    strobe_code = (op == OP_WRAP_FULL);
    step        = mm_en && go &&
                  ((wr_code && bus_wr) || (strobe_code && rd_strobe));
    if (step)        mc_d = ~mc_q;
    else if (bus_wr) mc_d = wr_mc;
    else             mc_d = mc_q;
  end
endmodule

// File: rtl/maint_wrap_reg.sv
module maint_wrap_reg
  import maint_wrap_pkg::*;
#(
  parameter int MDF_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      drv_clear,
  input  logic                      bus_wr,
  input  logic [MDF_W+6:0]          bus_wdata,
  input  logic                      go,
  input  logic                      rd_strobe,
  input  logic                      char_clk,
  input  logic                      cap_valid,
  input  logic [MDF_W-1:0]          cap_data,
  output logic [MDF_W+6:0]          rdata,
  output logic                      even_par,
  output logic                      no_wclk,
  output logic                      cripple,
  output logic                      no_crc_init,
  output logic                      stick_bit5,
  output logic                      bad_preamble,
  output logic                      eor_clr_go
);
  localparam int MM_BIT  = 0;
  localparam int OP_LSB  = 1;
  localparam int MC_BIT  = OP_LSB + OP_W;
  localparam int CC_BIT  = MC_BIT + 1;
  localparam int MDF_LSB = CC_BIT + 1;
  localparam int REG_W   = MDF_LSB + MDF_W;

  logic                  rst_s;
  logic                  mm_q, mm_d;
  logic [OP_W-1:0]       op_q, op_d;
  logic                  mc_q, mc_d, mc_step_d;
  logic [MDF_W-1:0]      mdf_q, mdf_d;
  logic                  cc_q;
  logic                  step;
  logic                  upd_en;
  logic                  unused_wr_cc;
  fault_ctl_t            ctl;

  assign unused_wr_cc = bus_wdata[CC_BIT];

  mwr_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  mwr_clk_step u_step (
    .mm_en     (mm_q),
    .go        (go),
    .op        (op_q),
    .bus_wr    (bus_wr),
    .rd_strobe (rd_strobe),
    .mc_q      (mc_q),
    .wr_mc     (bus_wdata[MC_BIT]),
    .mc_d      (mc_step_d),
    .step      (step)
  );

  // next state
  always_comb begin
    mm_d  = mm_q;
    op_d  = op_q;
    mdf_d = mdf_q;
    mc_d  = mc_step_d;
    if (bus_wr) begin
      mm_d  = bus_wdata[MM_BIT];
      op_d  = bus_wdata[MC_BIT-1:OP_LSB];
      mdf_d = bus_wdata[REG_W-1:MDF_LSB];
    end else if (cap_valid) begin
      mdf_d = cap_data;
    end
    if (drv_clear) begin
      mm_d  = 1'b0;
      op_d  = '0;
      mdf_d = '0;
      mc_d  = 1'b0;
    end
  end

  assign upd_en = drv_clear || bus_wr || cap_valid || step;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mm_q  <= 1'b0;
      op_q  <= '0;
      mc_q  <= 1'b0;
      mdf_q <= '0;
    end else if (upd_en) begin
      mm_q  <= mm_d;
      op_q  <= op_d;
      mc_q  <= mc_d;
      mdf_q <= mdf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) cc_q <= 1'b0;
    else        cc_q <= char_clk;
  end

  assign rdata = {mdf_q, cc_q, mc_q, op_q, mm_q};

  mwr_op_decode u_dec (
    .mm_en (mm_q),
    .op    (op_q),
    .go    (go),
    .ctl   (ctl)
  );

  assign even_par     = ctl.even_par;
  assign no_wclk      = ctl.no_wclk;
  assign cripple      = ctl.cripple;
  assign no_crc_init  = ctl.no_crc_init;
  assign stick_bit5   = ctl.stick_bit5;
  assign bad_preamble = ctl.bad_preamble;
  assign eor_clr_go   = ctl.eor_clr_go;
endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_s,
  input logic             drv_clear,
  input logic             bus_wr,
  input logic             go,
  input logic             rd_strobe,
  input logic             char_clk,
  input logic [REG_W-1:0] rdata,
  input logic             even_par,
  input logic             no_wclk,
  input logic             cripple,
  input logic             no_crc_init,
  input logic             stick_bit5,
  input logic             bad_preamble,
  input logic             eor_clr_go
);
  logic [6:0] ctl_v;
  logic [3:0] op_v;
  assign ctl_v = {eor_clr_go, bad_preamble, stick_bit5, no_crc_init,
                  cripple, no_wclk, even_par};
  assign op_v  = rdata[4:1];

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !rdata[0] |-> (ctl_v == 7'd0));

  assert_single_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(ctl_v));

  assert_eor_R8: assert property (@(posedge clk) disable iff (!rst_s)
    eor_clr_go |-> (go && rdata[0] && op_v == 4'd10));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_s)
    drv_clear |=> (rdata[REG_W-1:7] == '0 && rdata[5:0] == 6'd0));

  assert_cc_R3: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (rdata[6] == $past(char_clk)));

  assert_strobe_step_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (go && rdata[0] && op_v == 4'd3 && rd_strobe && !drv_clear)
      |=> (rdata[5] != $past(rdata[5])));

  assert_write_step_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (go && rdata[0] && bus_wr && !drv_clear &&
     (op_v == 4'd4 || op_v == 4'd5 || op_v == 4'd6))
      |=> (rdata[5] != $past(rdata[5])));
endmodule

bind maint_wrap_reg mwr_checker #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_s        (rst_s),
  .drv_clear    (drv_clear),
  .bus_wr       (bus_wr),
  .go           (go),
  .rd_strobe    (rd_strobe),
  .char_clk     (char_clk),
  .rdata        (rdata),
  .even_par     (even_par),
  .no_wclk      (no_wclk),
  .cripple      (cripple),
  .no_crc_init  (no_crc_init),
  .stick_bit5   (stick_bit5),
  .bad_preamble (bad_preamble),
  .eor_clr_go   (eor_clr_go)
);

// File: tb/tb_maint_wrap_reg.sv
module tb_maint_wrap_reg;
  logic        clk;
  logic        rst_n;
  logic        drv_clear, bus_wr, go, rd_strobe, char_clk, cap_valid;
  logic [15:0] bus_wdata;
  logic [8:0]  cap_data;
  logic [15:0] rdata;
  logic        even_par, no_wclk, cripple, no_crc_init;
  logic        stick_bit5, bad_preamble, eor_clr_go;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // model
  logic       m_mm, m_mc, m_cc;
  logic [3:0] m_op;
  logic [8:0] m_mdf;

  maint_wrap_reg dut (
    .clk(clk), .rst_n(rst_n), .drv_clear(drv_clear), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .go(go), .rd_strobe(rd_strobe),
    .char_clk(char_clk), .cap_valid(cap_valid), .cap_data(cap_data),
    .rdata(rdata), .even_par(even_par), .no_wclk(no_wclk),
    .cripple(cripple), .no_crc_init(no_crc_init), .stick_bit5(stick_bit5),
    .bad_preamble(bad_preamble), .eor_clr_go(eor_clr_go)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_reg();
    return {m_mdf, m_cc, m_mc, m_op, m_mm};
  endfunction

  function automatic logic [6:0] exp_ctl(input logic mm, input logic [3:0] op,
                                         input logic g);
    logic [6:0] v;
    v = 7'd0;
    if (mm) begin
      case (op)
        4'd2:  v[0] = 1'b1;
        4'd6:  v[1] = 1'b1;
        4'd7:  v[2] = 1'b1;
        4'd8:  v[3] = 1'b1;
        4'd9:  v[4] = 1'b1;
        4'd11: v[5] = 1'b1;
        4'd10: v[6] = g;
        default: v = 7'd0;
      endcase
    end
    return v;
  endfunction

  function automatic logic [6:0] act_ctl();
    return {eor_clr_go, bad_preamble, stick_bit5, no_crc_init,
            cripple, no_wclk, even_par};
  endfunction

  task automatic chk(input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    drv_clear = 0; bus_wr = 0; rd_strobe = 0; cap_valid = 0;
  endtask

  task automatic step(input string req);
    logic tog;
    @(posedge clk);
    if (drv_clear) begin
      m_mm = 0; m_op = 0; m_mc = 0; m_mdf = 0;
    end else begin
      tog = go && m_mm &&
            ((m_op == 4'd3 && rd_strobe) ||
             (bus_wr && (m_op == 4'd4 || m_op == 4'd5 || m_op == 4'd6)));
      if (tog)         m_mc = ~m_mc;
      else if (bus_wr) m_mc = bus_wdata[5];
      if (bus_wr) begin
        m_mm = bus_wdata[0]; m_op = bus_wdata[4:1]; m_mdf = bus_wdata[15:7];
      end else if (cap_valid) begin
        m_mdf = cap_data;
      end
    end
    m_cc = char_clk;
    @(negedge clk);
    chk(req, rdata, exp_reg());
    chk("R7", {9'd0, act_ctl()}, {9'd0, exp_ctl(m_mm, m_op, go)});
  endtask

  task automatic wr(input logic [8:0] mdf, input logic b6, input logic mc,
                    input logic [3:0] op, input logic mm, input string req);
    bus_wr = 1; bus_wdata = {mdf, b6, mc, op, mm};
    step(req);
    bus_wr = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [8];
    ops = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd10, 4'd2, 4'd13, 4'd9};
    void'($urandom(32'd4242));
    rst_n = 0; idle(); go = 0; char_clk = 0; bus_wdata = 0; cap_data = 0;
    m_mm = 0; m_op = 0; m_mc = 0; m_mdf = 0; m_cc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) step("R1");
    chk("R1", rdata, 16'd0);
    chk("R1", {9'd0, act_ctl()}, 16'd0);

    // R2 / R3: write with bit 6 set; bit 6 ignored
    wr(9'h1A5, 1'b1, 1'b1, 4'd2, 1'b1, "R2");
    chk("R3", rdata, {9'h1A5, 1'b0, 1'b1, 4'd2, 1'b1});
    chk("R7", {15'd0, even_par}, 16'd1);
    char_clk = 1; step("R3");
    chk("R3", {15'd0, rdata[6]}, 16'd1);
    char_clk = 0;

    // R4: capture alone, then capture against a write
    cap_valid = 1; cap_data = 9'h0F3; step("R4");
    chk("R4", {7'd0, rdata[15:7]}, 16'h00F3);
    cap_data = 9'h155; wr(9'h0AA, 1'b0, 1'b0, 4'd2, 1'b1, "R4");
    cap_valid = 0;
    chk("R4", {7'd0, rdata[15:7]}, 16'h00AA);

    // R5: write-step with code 0100
    go = 1;
    wr(9'd0, 1'b0, 1'b0, 4'd4, 1'b1, "R5");
    wr(9'd7, 1'b0, 1'b0, 4'd4, 1'b1, "R5");
    chk("R5", {15'd0, rdata[5]}, 16'd1);

    // R6: strobe-step with code 0011
    wr(9'd0, 1'b0, 1'b0, 4'd3, 1'b1, "R6");
    rd_strobe = 1; step("R6");
    chk("R6", {15'd0, rdata[5]}, 16'd1);
    go = 0; step("R6");
    chk("R6", {15'd0, rdata[5]}, 16'd1);
    rd_strobe = 0;

    // R8: end of record
    go = 1;
    wr(9'd0, 1'b0, 1'b0, 4'd10, 1'b1, "R8");
    chk("R8", {15'd0, eor_clr_go}, 16'd1);
    go = 0; #1;
    chk("R8", {15'd0, eor_clr_go}, 16'd0);

    // R9: gating and null codes
    wr(9'd0, 1'b0, 1'b0, 4'd7, 1'b0, "R9");
    chk("R9", {9'd0, act_ctl()}, 16'd0);
    wr(9'd0, 1'b0, 1'b0, 4'd13, 1'b1, "R9");
    chk("R9", {9'd0, act_ctl()}, 16'd0);

    // R10: clear beats write and capture
    drv_clear = 1; cap_valid = 1; cap_data = 9'h1FF;
    wr(9'h1FF, 1'b1, 1'b1, 4'd9, 1'b1, "R10");
    idle();
    chk("R10", rdata, 16'd0);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      drv_clear = ($urandom % 40) == 0;
      bus_wr    = ($urandom % 4) == 0;
      rd_strobe = $urandom % 2;
      cap_valid = ($urandom % 3) == 0;
      go        = ($urandom % 4) != 0;
      char_clk  = $urandom % 2;
      cap_data  = 9'($urandom);
      bus_wdata = 16'($urandom);
      bus_wdata[4:1] = ops[$urandom % 8];
      if (($urandom % 5) != 0) bus_wdata[0] = 1'b1;
      step("R2");
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule